// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block is the digital control core of a multi-channel switch driver. A serial bit stream is clocked into a shift register on the rising edge of a shift clock. A bank of level-sensitive latches sits behind the shift register, one latch per stage. Each latch output is the on/off command for one channel, where 1 means on.

An active-low latch enable makes the latches transparent while it is low. When it goes high they freeze. This lets a new pattern be shifted in without disturbing the switches, and then applied all at once. An active-high clear has priority over every other input. It empties the shift register and forces every switch command off at once, without waiting for a clock edge.

The last shift stage is brought out as a serial output. Several instances can therefore be daisy-chained on a shared clock, with each instance taking one register's worth of clocks.

Top module: `serial_switch_ctrl`

## Requirements
- R1: On each rising edge of `sclk`, with `clr` low, `sdi` is captured into stage 0 and stage n takes the previous content of stage n-1, for every stage up to the last.
- R2: `sdo` always equals the last stage (stage NUM_CH-1). A bit presented on `sdi` therefore appears on `sdo` after NUM_CH rising edges.
- R3: While `latch_n` is low and `clr` is low, `sw_on[i]` continuously equals shift stage i, where 1 means switch on and 0 means switch off. This includes the case where `latch_n` falls between clock edges.
- R4: While `latch_n` is high, clocking and `sdi` activity leave `sw_on` unchanged.
- R5: `sw_on` keeps the shift-register contents that were present at the moment `latch_n` rose.
- R6: While `clr` is high, the shift register and `sw_on` read all zeros and `sdo` reads 0. This takes effect without a clock edge and regardless of `latch_n`, `sdi` or `sclk`.
- R7: After `clr` falls, the register stays all zeros until the next rising edge of `sclk`.
- R8: With K instances chained `sdo` to `sdi` on a shared clock, K*NUM_CH bits are loaded MSB first. After that, instance j (0 = nearest the source) holds bits [j*NUM_CH+NUM_CH-1 : j*NUM_CH] of the word. The word MSB lands on channel NUM_CH-1 of the last instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock; shifting happens on its rising edge |
| sdi | input | 1 | Serial data into stage 0 |
| latch_n | input | 1 | Latch enable, active low; low = transparent, high = hold |
| clr | input | 1 | Asynchronous clear, active high, highest priority |
| sdo | output | 1 | Serial data out, the last shift stage, for cascading |
| sw_on | output | NUM_CH | Per-channel switch-on command; bit i is fed from stage i |

## Verification
The hardest situation to reach from the ports is a latch that is frozen while its shift register keeps changing underneath it. Reaching it needs `latch_n` to rise between two clock edges, and then a whole new word to be shifted through a chain of instances. A clear arriving in the middle of that hold is the other hard-to-reach case. The bench loads random words MSB first through a three-instance chain with the latches open. It raises `latch_n` mid-cycle and shifts a second random word while checking that the outputs do not move. It then reopens the latches to see the hidden word appear. Finally it pulses `clr` in the middle of a cycle, keeps it high across edges with `sdi` held at 1, and releases it between edges to confirm the all-zero state lasts until the next edge.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  // Default number of channels (shift stages and latches) per instance.
  parameter int unsigned SWCTL_CHANNELS = 8;
endpackage

// File: rtl/swctl_shift_reg.sv
module swctl_shift_reg #(
  parameter int unsigned NUM_CH = swctl_pkg::SWCTL_CHANNELS
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              sdi,
  output logic [NUM_CH-1:0] stage
);
  localparam int unsigned LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] stage_nxt;

  // Next state: serial bit enters stage 0, every stage moves up by one.
  always_comb begin
    stage_nxt = {stage[LAST-1:0], sdi};
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      stage <= '0;
    end else begin
      stage <= stage_nxt;
    end
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (clr)
    !clr |=> (stage[0] == $past(sdi))); // R1

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (clr)
    !clr |=> (stage[LAST:1] == $past(stage[LAST-1:0]))); // R1

  AST_CLR_EMPTY: assert property (@(posedge clk)
    clr |-> (stage == '0)); // R6
endmodule

// File: rtl/swctl_latch_bank.sv
module swctl_latch_bank #(
  parameter int unsigned NUM_CH = swctl_pkg::SWCTL_CHANNELS
) (
  input  logic              obs_clk,
  input  logic              clr,
  input  logic              le_n,
  input  logic [NUM_CH-1:0] d,
  output logic [NUM_CH-1:0] q
);
  // One level-sensitive cell per channel; clear dominates the enable.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
    logic held;

    always_latch begin
      if (clr) begin
        held <= 1'b0;
      end else if (!le_n) begin
        held <= d[ch];
      end
    end

    assign q[ch] = held;
  end

  AST_HOLD_FROZEN: assert property (@(posedge obs_clk) disable iff (clr)
    (le_n && $past(le_n)) |-> $stable(q)); // R4

  AST_LATCH_CLEARED: assert property (@(posedge obs_clk)
    clr |-> (q == '0)); // R6
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl #(
  parameter int unsigned NUM_CH = swctl_pkg::SWCTL_CHANNELS
) (
  input  logic              sclk,
  input  logic              sdi,
  input  logic              latch_n,
  input  logic              clr,
  output logic              sdo,
  output logic [NUM_CH-1:0] sw_on
);
  localparam int unsigned LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] stage;

  swctl_shift_reg #(.NUM_CH(NUM_CH)) u_shift (
    .clk   (sclk),
    .clr   (clr),
    .sdi   (sdi),
    .stage (stage)
  );

  swctl_latch_bank #(.NUM_CH(NUM_CH)) u_latch (
    .obs_clk (sclk),
    .clr     (clr),
    .le_n    (latch_n),
    .d       (stage),
    .q       (sw_on)
  );

  assign sdo = stage[LAST];

  AST_CASCADE_OUT: assert property (@(posedge sclk) disable iff (clr)
    !clr |=> (sdo == $past(stage[LAST-1]))); // R2

  AST_CLEAR_ALL_OFF: assert property (@(posedge sclk)
    clr |-> ((sw_on == '0) && !sdo)); // R6
endmodule

// File: tb/serial_switch_ctrl_bench.sv
module serial_switch_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CHAIN      = 3;
  localparam int NCH        = 8;
  localparam int TOT        = CHAIN * NCH;

  typedef struct {
    int             kind;  // 0: all sw_on, 1: last sdo, 2: first-instance sdo
    logic [TOT-1:0] exp;
    string          tag;
  } item_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic           sdi, latch_n, clr;
  logic [CHAIN:0] link;
  logic [TOT-1:0] sw_all;

  assign link[0] = sdi;

  for (genvar g = 0; g < CHAIN; g++) begin : gen_chain
    serial_switch_ctrl #(.NUM_CH(NCH)) u_serial_switch_ctrl (
      .sclk    (clk),
      .sdi     (link[g]),
      .latch_n (latch_n),
      .clr     (clr),
      .sdo     (link[g+1]),
      .sw_on   (sw_all[g*NCH +: NCH])
    );
  end

  item_t          sb[$];
  event           chk_ev;
  int             n_chk  = 0;
  int             n_fail = 0;
  logic [TOT-1:0] model;
  logic [TOT-1:0] exp_sw;
  logic [TOT-1:0] word;

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        case (it.kind)
          0: if (sw_all !== it.exp) begin
               n_fail++;
               $display("FAIL %s: sw_on actual %h expected %h", it.tag, sw_all, it.exp);
             end
          1: if (link[CHAIN] !== it.exp[0]) begin
               n_fail++;
               $display("FAIL %s: last sdo actual %b expected %b", it.tag, link[CHAIN], it.exp[0]);
             end
          default: if (link[1] !== it.exp[0]) begin
               n_fail++;
               $display("FAIL %s: first sdo actual %b expected %b", it.tag, link[1], it.exp[0]);
             end
        endcase
      end
    end
  end

  task automatic push(input int kind, input logic [TOT-1:0] e, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = e;
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic flush();
    ->chk_ev;
    #1;
  endtask

  task automatic expect_all(input string tag);
    push(0, exp_sw, tag);
    push(1, {{(TOT-1){1'b0}}, model[TOT-1]}, tag);
    push(2, {{(TOT-1){1'b0}}, model[NCH-1]}, tag);
    flush();
  endtask

  // Drive one bit, take one rising edge, update the model, check.
  task automatic shift_bit(input logic b, input string tag);
    sdi = b;
    @(posedge clk);
    model = {model[TOT-2:0], b};
    if (!latch_n) exp_sw = model;
    #2;
    expect_all(tag);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    sdi     = 1'b0;
    latch_n = 1'b1;
    clr     = 1'b0;
    #1;
    clr     = 1'b1;
    model   = '0;
    exp_sw  = '0;
    repeat (3) @(posedge clk);
    #2;
    expect_all("R6 reset state");

    // Release clear between edges with latches open: still zero (R7).
    latch_n = 1'b0;
    sdi     = 1'b1;
    clr     = 1'b0;
    #1;
    expect_all("R7 zero after release");
    shift_bit(1'b1, "R7 R1 first edge after release");

    for (int iter = 0; iter < 3; iter++) begin
      // Transparent load of a random word, MSB first (R1, R2, R3).
      word = TOT'($urandom());
      for (int i = TOT - 1; i >= 0; i--) shift_bit(word[i], "R1 R2 R3 transparent shift");
      exp_sw = word;
      expect_all("R8 chained MSB-first placement");

      // Raise latch enable between edges; value at that moment retained (R5).
      latch_n = 1'b1;
      #1;
      expect_all("R5 captured at latch rise");

      // Shift a second word with the latches frozen (R4).
      for (int i = 0; i < TOT; i++) shift_bit(1'($urandom()), "R4 hold while shifting");

      // Reopen: outputs jump to the hidden register contents (R3).
      latch_n = 1'b0;
      exp_sw  = model;
      #1;
      expect_all("R3 reopen shows register");

      // Close again after one open edge, then clear mid-cycle (R6).
      shift_bit(1'b1, "R3 open edge");
      latch_n = 1'b1;
      #1;
      clr    = 1'b1;
      model  = '0;
      exp_sw = '0;
      #1;
      expect_all("R6 clear immediate over hold");
      sdi     = 1'b1;
      latch_n = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      expect_all("R6 clear ignores clock data enable");
      clr = 1'b0;
      #1;
      expect_all("R7 zero until next edge");
      shift_bit(1'b1, "R7 R1 resume after clear");
    end

    report();
  end
endmodule